// File: doc/BRIEF.md
# Sign-Magnitude Sequential Integer Multiplier

This block multiplies two two's-complement integers over several clock cycles and returns the low word of the product. A one-cycle start strobe captures both operands. In the same cycle the block turns each operand into its magnitude and records whether the product must be negative. It then processes one multiplier bit per cycle, starting from the most significant bit. In each step it doubles the running sum and adds the multiplicand magnitude when the current multiplier bit is one. On the final step it negates the sum if the recorded sign says so, publishes the word and raises a one-cycle completion pulse.

The latency is fixed and does not depend on the operand values. This lets a controller that issues a product know exactly when the result will be ready. The upper half of the full product is discarded. No overflow indication is produced.

Top module: `smag_mul`

## Requirements
- R1: While the synchronous reset is held and in the first cycle after it, `busy` is 0, `done` is 0 and `result` is 0.
- R2: A `start` pulse sampled while `busy` is 0 captures `op_a` and `op_b`, and `busy` is 1 from the next cycle on.
- R3: A `start` pulse sampled while `busy` is 1 is ignored. The running operation finishes at its original time with the product of the operands captured first.
- R4: After an accepted start, `busy` stays 1 for exactly WIDTH cycles (32 by default). `done` is 1 in the cycle that follows, with `busy` back at 0.
- R5: `result` equals the low WIDTH bits of the signed product `op_a * op_b`. Any bits above that are dropped without any flag.
- R6: The sign of the result follows the XOR of the two operand sign bits (bit WIDTH-1). A negative times a negative gives a positive product, and any operand of zero gives zero.
- R7: The most negative operand value (only bit WIDTH-1 set) still gives the correct low word. For example, 0x80000000 times -1 gives 0x80000000, and 0x80000000 times 0x80000000 gives 0.
- R8: `done` is high for a single cycle per operation. `result` keeps its value in every cycle until the next operation completes.
- R9: The latency is the same for all operand values, including when both operands are negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe; captures the operands when idle |
| op_a | input | WIDTH | Multiplier operand, two's complement |
| op_b | input | WIDTH | Multiplicand operand, two's complement |
| busy | output | 1 | High while the iteration loop runs |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | WIDTH | Low WIDTH bits of the signed product |

## Verification
The embedded assertions check the control behaviour on every cycle:
- an idle start raises `busy`;
- a start during an operation does not disturb the iteration count;
- the count stays in range while busy;
- `done` is a single-cycle pulse that appears exactly where `busy` falls;
- `result` never moves outside a completion cycle.

Only the bench scenarios can show that the numeric product is right. These scenarios cover random signed operands, sign combinations, the most negative value and zero. The bench also shows that the cycle count from start to done is identical across all of them.

// File: rtl/smag_mul_pkg.sv
package smag_mul_pkg;

    localparam int unsigned SMUL_WIDTH_DEFAULT = 32;

    // bits needed to hold an iteration count from 0 up to w
    function automatic int unsigned smul_cnt_bits(input int unsigned w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/smag_mul_cond.sv
// Operand conditioning: magnitudes plus the sign the product must carry.
module smag_mul_cond #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] raw_a,
    input  logic [WIDTH-1:0] raw_b,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b,
    output logic             neg
);
    logic sign_a;
    logic sign_b;

    always_comb begin
        sign_a = raw_a[WIDTH-1];
        sign_b = raw_b[WIDTH-1];
        // the most negative value maps onto itself, which is the correct
        // magnitude modulo 2**WIDTH
        mag_a  = sign_a ? (~raw_a + 1'b1) : raw_a;
        mag_b  = sign_b ? (~raw_b + 1'b1) : raw_b;
        neg    = sign_a ^ sign_b;
    end
endmodule

// File: rtl/smag_mul_step.sv
// One MSB-first shift-and-add iteration.
module smag_mul_step #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] mplier,
    input  logic [WIDTH-1:0] mcand,
    output logic [WIDTH-1:0] acc_nx,
    output logic [WIDTH-1:0] mplier_nx
);
    logic [WIDTH-1:0] acc_dbl;

    always_comb begin
        acc_dbl   = {acc[WIDTH-2:0], 1'b0};
        acc_nx    = mplier[WIDTH-1] ? (acc_dbl + mcand) : acc_dbl;
        mplier_nx = {mplier[WIDTH-2:0], 1'b0};
    end
endmodule

// File: rtl/smag_mul_fix.sv
// Final sign fix-up of the accumulated magnitude.
module smag_mul_fix #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] mag,
    input  logic             neg,
    output logic [WIDTH-1:0] word
);
    always_comb begin
        word = neg ? (~mag + 1'b1) : mag;
    end
endmodule

// File: rtl/smag_mul.sv
module smag_mul
    import smag_mul_pkg::*;
#(
    parameter int unsigned WIDTH = SMUL_WIDTH_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    localparam int unsigned CNT_W = smul_cnt_bits(WIDTH);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             neg;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] mplier;
        logic [WIDTH-1:0] mcand;
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] res;
    } smul_state_t;

    smul_state_t st_d;
    smul_state_t st_q;

    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    logic             neg_in;
    logic [WIDTH-1:0] acc_step;
    logic [WIDTH-1:0] mplier_step;
    logic [WIDTH-1:0] signed_word;

    smag_mul_cond #(.WIDTH(WIDTH)) u_cond (
        .raw_a (op_a),
        .raw_b (op_b),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .neg   (neg_in)
    );

    smag_mul_step #(.WIDTH(WIDTH)) u_step (
        .acc       (st_q.acc),
        .mplier    (st_q.mplier),
        .mcand     (st_q.mcand),
        .acc_nx    (acc_step),
        .mplier_nx (mplier_step)
    );

    smag_mul_fix #(.WIDTH(WIDTH)) u_fix (
        .mag  (acc_step),
        .neg  (st_q.neg),
        .word (signed_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.neg    = neg_in;
                st_d.mplier = mag_a;
                st_d.mcand  = mag_b;
                st_d.acc    = '0;
                st_d.cnt    = CNT_W'(WIDTH);
            end
        end else begin
            // a start strobe here has no effect
            st_d.acc    = acc_step;
            st_d.mplier = mplier_step;
            st_d.cnt    = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = signed_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.res;

    // R2: an idle start launches an operation
    a_r2_start_launches: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3: a start while running leaves the iteration count on its path
    a_r3_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && busy && st_q.cnt > CNT_W'(1)) |=> (busy && st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R4: count stays in range while running
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (st_q.cnt != '0 && st_q.cnt <= CNT_W'(WIDTH)));

    // R4: done appears exactly where busy falls
    a_r4_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R4: done never coincides with busy
    a_r4_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: result only moves on a completion
    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || $stable(result)));
endmodule

// File: tb/smag_mul_bench.sv
`timescale 1ns/1ps
module smag_mul_bench;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;
    int first_lat = -1;

    always #2 clk = ~clk;   // 250 MHz

    smag_mul #(.WIDTH(W)) u_smag_mul (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [63:0] p;
        p = 64'(signed'(a)) * 64'(signed'(b));
        return p[W-1:0];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // mid: cycles after launch at which to pulse a second start (0 = none)
    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                           input string req, input int mid);
        int lat;
        logic [W-1:0] exp;
        exp = ref_mul(a, b);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", 64'(busy), 64'(1));
        lat = 0;
        while (!done && lat < 100) begin
            if (mid != 0 && lat == mid) begin
                op_a = ~a; op_b = b + 32'd7; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check({req, " R4 latency"}, 64'(lat), 64'(W));
        check({req, " R5 product"}, 64'(result), 64'(exp));
        check("R4 busy low at done", 64'(busy), 64'(0));
        if (first_lat < 0) first_lat = lat;
        check("R9 same latency", 64'(lat), 64'(first_lat));
        @(negedge clk);
        check("R8 done one cycle", 64'(done), 64'(0));
        check("R8 result held", 64'(result), 64'(exp));
        if (mid != 0) check("R3 no relaunch", 64'(busy), 64'(0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 busy reset", 64'(busy), 64'(0));
        check("R1 done reset", 64'(done), 64'(0));
        check("R1 result reset", 64'(result), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", 64'({busy, done}), 64'(0));
        check("R1 result after reset", 64'(result), 64'(0));

        run_mul(32'd6, 32'd7, "R5 small", 0);
        run_mul(32'hFFFF_FFFB, 32'hFFFF_FFF9, "R6 neg*neg", 0);
        run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 both -1", 0);
        run_mul(32'd12345, 32'hFFFF_FF00, "R6 pos*neg", 0);
        run_mul(32'hFFFF_FF00, 32'd0, "R6 zero", 0);
        run_mul(32'h8000_0000, 32'hFFFF_FFFF, "R7 min*-1", 0);
        check("R7 min*-1 literal", 64'(result), 64'(32'h8000_0000));
        run_mul(32'h8000_0000, 32'h8000_0000, "R7 min*min", 0);
        check("R7 min*min literal", 64'(result), 64'(0));
        run_mul(32'hFFFF_FFFF, 32'h8000_0000, "R7 -1*min", 0);
        run_mul(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R5 overflow wrap", 0);
        run_mul(32'd1000, 32'hFFFF_FFFD, "R3 start while busy", 5);
        run_mul(32'hDEAD_BEEF, 32'h1234_5678, "R3 late start", 31);

        void'($urandom(32'd20240607));
        for (int i = 0; i < 60; i++) begin
            run_mul($urandom(), $urandom(), "R5 random", 0);
        end
        for (int i = 0; i < 20; i++) begin
            run_mul($urandom() | 32'h8000_0000, $urandom() | 32'h8000_0000, "R6 random neg", 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule